// File: doc/BRIEF.md
# PCI Interrupt Swizzle Router

This block gathers level interrupts from PCI devices and presents them to a legacy 16-input interrupt controller. Each device raises or lowers one of its four pins (INTA through INTD). The block rotates that pin by the device's slot number to choose one of four shared link lines. A byte-wide route register for each link then picks which controller input the link drives. When several active links point at the same input, that input is the OR of all of them.

Interrupt sources report level changes on an event port. Each event carries a device/function number, a pin number and the new level. The block keeps one stored level per link. It rebuilds the whole output vector from those levels and the current routes on every cycle. A route rewrite therefore releases the old target at once if no other link still uses it. A configuration write port loads the four route registers. A parameter picks the reset contents of the routes: either every link disabled, or a fixed preset.

Top module: `pci_irq_router`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, `irq_out` is all zero and every stored link level is low.
- R2: An event with device/function number `d` (device number is `d[7:3]`; the function bits `d[2:0]` are ignored) and pin `p` (0 = INTA, 1 = INTB, 2 = INTC, 3 = INTD) addresses link `(p + d[7:3] - 1) mod 4`.
- R3: Each link keeps the level carried by the latest event that addressed it. A later event for the same link overwrites the level, whichever device it comes from.
- R4: A write with `cfg_addr` equal to `ROUTE_BASE + k` (0x60 to 0x63 by default, for k = 0 to 3) loads all 8 bits of `cfg_wdata` into the route of link k. Writes to any other address change no route.
- R5: A route value of `NUM_IRQ` or more (16 or more by default, e.g. 0x10, 0x80, 0xFF) disables its link, so that link drives no output bit.
- R6: Output bit `i` is high exactly when at least one link whose route equals `i` has a high stored level.
- R7: After a route is rewritten, the output it used to drive follows R6 again. It falls if no other high link still routes to it, and the new target rises if the link is high.
- R8: An event or route write sampled at clock edge k updates the stored state at that edge. `irq_out` shows the change after edge k+1 and not before.
- R9: With `RESET_PRESET` = 0 every route resets to 0x80 (disabled). With `RESET_PRESET` = 1 links 0 and 1 reset to IRQ 10 and links 2 and 3 reset to IRQ 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_valid | input | 1 | A pin level event is presented this cycle |
| pin_devfn | input | 8 | Device/function number of the source |
| pin_num | input | 2 | Source pin, 0 = INTA to 3 = INTD |
| pin_level | input | 1 | New level of that pin |
| cfg_we | input | 1 | Route register write strobe |
| cfg_addr | input | 8 | Route register address |
| cfg_wdata | input | 8 | Route register write data |
| irq_out | output | NUM_IRQ | Level interrupt vector to the controller |

## Verification
The hardest case to reach from the ports is a route rewrite while the link is still high and a second link shares the old target. The old output has to stay up for the other link's sake and fall only when that link leaves too. The stimulus first points two links at one input and raises both. It then moves one link elsewhere and later disables the other. A reference model checks every cycle, so the release of the old target and the rise of the new one are both seen on the right cycle. A separate phase uses events from different devices that land on the same link, to show that the latest event wins. Random traffic mixes route values on both sides of the disable limit with writes just outside the register window.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

    localparam int LINK_COUNT = 4;
    localparam int ROUTE_W    = 8;
    localparam int DEVFN_W    = 8;

    typedef logic [1:0]         link_idx_t;
    typedef logic [ROUTE_W-1:0] route_t;

    localparam route_t ROUTE_OFF = 8'h80;

    typedef struct packed {
        logic               valid;
        logic [DEVFN_W-1:0] devfn;
        logic [1:0]         pin;
        logic               level;
    } pin_event_t;

    typedef struct packed {
        logic               we;
        logic [7:0]         addr;
        route_t             data;
    } route_wr_t;

    // slot rotation: device number low bits added to the pin, minus one
    function automatic link_idx_t swizzle(logic [DEVFN_W-1:0] devfn, logic [1:0] pin);
        link_idx_t dev_lo;
        dev_lo = devfn[4:3];
        return pin + dev_lo - 2'd1;
    endfunction

    function automatic route_t preset_route(int link);
        return (link < 2) ? route_t'(10) : route_t'(11);
    endfunction

endpackage

// File: rtl/pirq_link_store.sv
module pirq_link_store
    import pirq_route_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  pin_event_t            ev,
    output logic [LINK_COUNT-1:0] link_lvl
);

    link_idx_t ev_link;

    always_comb ev_link = swizzle(ev.devfn, ev.pin);

    always_ff @(posedge clk) begin
        if (rst) begin
            link_lvl <= '0;
        end else if (ev.valid) begin
            link_lvl[ev_link] <= ev.level;
        end
    end

    // R3: the addressed link takes the event level
    a_r3_capture_level: assert property (@(posedge clk) disable iff (rst)
        ev.valid |=> link_lvl[$past(ev_link)] == $past(ev.level));

    for (genvar i = 0; i < LINK_COUNT; i++) begin : g_hold
        // R2: links not addressed by the event keep their level
        a_r2_other_links_hold: assert property (@(posedge clk) disable iff (rst)
            !(ev.valid && ev_link == link_idx_t'(i)) |=> $stable(link_lvl[i]));
    end

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
    import pirq_route_pkg::*;
#(
    parameter bit RESET_PRESET = 1'b0,
    parameter int ROUTE_BASE   = 8'h60
) (
    input  logic                           clk,
    input  logic                           rst,
    input  route_wr_t                      wr,
    output route_t [LINK_COUNT-1:0]        routes
);

    localparam int ROUTE_LAST = ROUTE_BASE + LINK_COUNT - 1;

    for (genvar i = 0; i < LINK_COUNT; i++) begin : g_route
        localparam logic [7:0] SLOT_ADDR = 8'(ROUTE_BASE + i);
        localparam route_t     RST_VAL   = RESET_PRESET ? preset_route(i) : ROUTE_OFF;

        always_ff @(posedge clk) begin
            if (rst) begin
                routes[i] <= RST_VAL;
            end else if (wr.we && wr.addr == SLOT_ADDR) begin
                routes[i] <= wr.data;
            end
        end
    end

    // R4: writes outside the route window leave every route alone
    a_r4_foreign_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (!wr.we || int'(wr.addr) < ROUTE_BASE || int'(wr.addr) > ROUTE_LAST)
        |=> $stable(routes));

    // R9: reset value of the routes follows the variant parameter
    a_r9_reset_routes: assert property (@(posedge clk)
        rst |=> (RESET_PRESET ? (routes[0] == route_t'(10) && routes[3] == route_t'(11))
                              : (routes[0] == ROUTE_OFF && routes[3] == ROUTE_OFF)));

endmodule

// File: rtl/pirq_irq_merge.sv
module pirq_irq_merge
    import pirq_route_pkg::*;
#(
    parameter int NUM_IRQ = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [LINK_COUNT-1:0]   link_lvl,
    input  route_t [LINK_COUNT-1:0] routes,
    output logic [NUM_IRQ-1:0]      irq_q
);

    localparam int IW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] hit;

    for (genvar j = 0; j < NUM_IRQ; j++) begin : g_irq
        always_comb begin
            hit[j] = 1'b0;
            for (int p = 0; p < LINK_COUNT; p++) begin
                if (link_lvl[p] && routes[p] == route_t'(j)) begin
                    hit[j] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
        end else begin
            irq_q <= hit;
        end
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk) rst |=> irq_q == '0);

    // R5: never more outputs lit than there are links
    a_r5_bounded_fanout: assert property (@(posedge clk) disable iff (rst)
        $countones(irq_q) <= LINK_COUNT);

    for (genvar p = 0; p < LINK_COUNT; p++) begin : g_link_chk
        // R6: a high, enabled link lights its target on the next cycle
        a_r6_link_drives_target: assert property (@(posedge clk) disable iff (rst)
            (link_lvl[p] && int'(routes[p]) < NUM_IRQ)
            |=> irq_q[$past(routes[p][IW-1:0])]);
    end

endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
    import pirq_route_pkg::*;
#(
    parameter int NUM_IRQ      = 16,
    parameter bit RESET_PRESET = 1'b0,
    parameter int ROUTE_BASE   = 8'h60
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pin_valid,
    input  logic [7:0]         pin_devfn,
    input  logic [1:0]         pin_num,
    input  logic               pin_level,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [7:0]         cfg_wdata,
    output logic [NUM_IRQ-1:0] irq_out
);

    pin_event_t              ev;
    route_wr_t               wr;
    logic [LINK_COUNT-1:0]   link_lvl;
    route_t [LINK_COUNT-1:0] routes;

    always_comb begin
        ev.valid = pin_valid;
        ev.devfn = pin_devfn;
        ev.pin   = pin_num;
        ev.level = pin_level;
        wr.we    = cfg_we;
        wr.addr  = cfg_addr;
        wr.data  = cfg_wdata;
    end

    pirq_link_store u_store (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .link_lvl (link_lvl)
    );

    pirq_route_regs #(
        .RESET_PRESET (RESET_PRESET),
        .ROUTE_BASE   (ROUTE_BASE)
    ) u_routes (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .routes (routes)
    );

    pirq_irq_merge #(
        .NUM_IRQ (NUM_IRQ)
    ) u_merge (
        .clk      (clk),
        .rst      (rst),
        .link_lvl (link_lvl),
        .routes   (routes),
        .irq_q    (irq_out)
    );

    // R8: with no event and no write, the output settles and holds
    a_r8_quiet_holds: assert property (@(posedge clk) disable iff (rst)
        (!pin_valid && !cfg_we) ##1 (!pin_valid && !cfg_we) |=> $stable(irq_out));

endmodule

// File: tb/test_pci_irq_router.sv
module test_pci_irq_router;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin_valid = 1'b0;
    logic [7:0]  pin_devfn = '0;
    logic [1:0]  pin_num = '0;
    logic        pin_level = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [15:0] irq_a, irq_b;

    int    total = 0;
    int    bad = 0;
    bit    started = 0;
    bit    finished = 0;
    string phase = "R1";

    always #10 clk = ~clk;

    pci_irq_router i_pci_irq_router (
        .clk(clk), .rst(rst), .pin_valid(pin_valid), .pin_devfn(pin_devfn),
        .pin_num(pin_num), .pin_level(pin_level), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_out(irq_a));

    pci_irq_router #(.RESET_PRESET(1'b1)) i_pci_irq_router_preset (
        .clk(clk), .rst(rst), .pin_valid(pin_valid), .pin_devfn(pin_devfn),
        .pin_num(pin_num), .pin_level(pin_level), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq_out(irq_b));

    // reference model
    int          lv[4];
    int          rt_a[4];
    int          rt_b[4];
    logic [15:0] exp_a = '0, exp_b = '0;

    function automatic logic [15:0] combine(int levels[4], int rts[4]);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++)
            for (int p = 0; p < 4; p++)
                if (levels[p] != 0 && rts[p] == i) r[i] = 1'b1;
        return r;
    endfunction

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            for (int p = 0; p < 4; p++) begin
                lv[p] = 0;
                rt_a[p] = 'h80;
                rt_b[p] = (p < 2) ? 10 : 11;
            end
            exp_a = '0;
            exp_b = '0;
        end else begin
            exp_a = combine(lv, rt_a);
            exp_b = combine(lv, rt_b);
            if (pin_valid) begin
                int idx;
                idx = int'(pin_num) + int'(pin_devfn >> 3) - 1;
                idx = ((idx % 4) + 4) % 4;
                lv[idx] = pin_level ? 1 : 0;
            end
            if (cfg_we && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) begin
                rt_a[cfg_addr - 8'h60] = int'(cfg_wdata);
                rt_b[cfg_addr - 8'h60] = int'(cfg_wdata);
            end
        end
    end

    always @(negedge clk) begin
        if (started && !finished) begin
            total++;
            if (irq_a !== exp_a) begin
                bad++;
                $display("FAIL %s default variant actual=%h expected=%h", phase, irq_a, exp_a);
            end
            total++;
            if (irq_b !== exp_b) begin
                bad++;
                $display("FAIL %s preset variant actual=%h expected=%h", phase, irq_b, exp_b);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pin_ev(int devfn, int pin, int lvl);
        pin_valid = 1'b1;
        pin_devfn = 8'(devfn);
        pin_num   = 2'(pin);
        pin_level = (lvl != 0);
        @(negedge clk);
        pin_valid = 1'b0;
    endtask

    task automatic wr_route(int addr, int data);
        cfg_we    = 1'b1;
        cfg_addr  = 8'(addr);
        cfg_wdata = 8'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic direct_check(string req, logic actual, logic expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s direct actual=%b expected=%b", req, actual, expected);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle(3);
        phase = "R1";
        rst = 1'b0;
        idle(2);

        // R9: link 0 raised; default variant silent, preset drives IRQ 10
        phase = "R9";
        pin_ev(8'h08, 0, 1);
        idle(2);
        direct_check("R9", irq_b[10], 1'b1);
        direct_check("R9", irq_a[10], 1'b0);
        pin_ev(8'h08, 0, 0);
        idle(2);

        // R4: window writes and two just outside it
        phase = "R4";
        wr_route('h60, 3);
        wr_route('h61, 5);
        wr_route('h62, 7);
        wr_route('h63, 9);
        wr_route('h64, 1);
        wr_route('h5F, 2);
        for (int p = 0; p < 4; p++) pin_ev(8'h08, p, 1);
        idle(2);
        direct_check("R4", irq_a[1] | irq_a[2], 1'b0);
        for (int p = 0; p < 4; p++) pin_ev(8'h08, p, 0);
        idle(2);

        // R2: sweep device numbers (function bits set) and pins
        phase = "R2";
        for (int d = 0; d < 8; d++) begin
            for (int p = 0; p < 4; p++) begin
                pin_ev(d * 8 + 5, p, 1);
                idle(2);
                pin_ev(d * 8 + 5, p, 0);
                idle(1);
            end
        end

        // R3: a different device lowers the same link
        phase = "R3";
        pin_ev(8'h08, 0, 1);
        idle(2);
        pin_ev(8'h10, 3, 0);
        idle(2);
        direct_check("R3", irq_a[3], 1'b0);

        // R5: values at and above the limit disable link 0
        phase = "R5";
        pin_ev(8'h08, 0, 1);
        wr_route('h60, 'h10);
        idle(2);
        wr_route('h60, 'h80);
        idle(2);
        wr_route('h60, 'hFF);
        idle(2);
        wr_route('h60, 15);
        idle(2);
        pin_ev(8'h08, 0, 0);
        idle(1);

        // R6: two links share IRQ 12
        phase = "R6";
        wr_route('h60, 12);
        wr_route('h61, 12);
        pin_ev(8'h08, 0, 1);
        pin_ev(8'h08, 1, 1);
        idle(2);
        pin_ev(8'h08, 0, 0);
        idle(2);
        direct_check("R6", irq_a[12], 1'b1);
        pin_ev(8'h08, 1, 0);
        idle(2);

        // R7: move a live link while another shares its old target
        phase = "R7";
        wr_route('h60, 5);
        wr_route('h61, 5);
        pin_ev(8'h08, 0, 1);
        pin_ev(8'h08, 1, 1);
        idle(2);
        wr_route('h60, 6);
        idle(2);
        direct_check("R7", irq_a[5], 1'b1);
        direct_check("R7", irq_a[6], 1'b1);
        wr_route('h61, 'h80);
        idle(2);
        direct_check("R7", irq_a[5], 1'b0);
        pin_ev(8'h08, 0, 0);
        idle(2);

        // R8: one cycle of latency after the state update
        phase = "R8";
        wr_route('h62, 4);
        idle(1);
        pin_ev(8'h08, 2, 1);
        direct_check("R8", irq_a[4], 1'b0);
        idle(1);
        direct_check("R8", irq_a[4], 1'b1);
        pin_ev(8'h08, 2, 0);
        direct_check("R8", irq_a[4], 1'b1);
        idle(1);
        direct_check("R8", irq_a[4], 1'b0);

        // mixed random traffic
        phase = "R6";
        for (int n = 0; n < 400; n++) begin
            pin_valid = ($urandom_range(0, 1) == 1);
            pin_devfn = 8'($urandom_range(0, 255));
            pin_num   = 2'($urandom_range(0, 3));
            pin_level = ($urandom_range(0, 1) == 1);
            cfg_we    = ($urandom_range(0, 3) == 0);
            cfg_addr  = 8'($urandom_range('h5E, 'h65));
            cfg_wdata = ($urandom_range(0, 3) == 0) ? 8'($urandom_range(16, 255))
                                                    : 8'($urandom_range(0, 15));
            @(negedge clk);
        end
        pin_valid = 1'b0;
        cfg_we = 1'b0;
        idle(3);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule